// File: doc/BRIEF.md
# Segmented Bus Inversion Codec

This block sits between a wide parallel data path and its pads. It cuts down how many lines are pulled to the low level in each data phase. A 64-bit word is split into four 16-bit segments, and each segment has its own active-low inversion flag. On the way out, the encoder counts how many lines of each segment would sit low. If that count is more than half the segment width, it flips the segment and asserts the segment's flag. On the way in, the decoder undoes the flip for every segment whose flag is asserted.

Data on the block's logical side uses ordinary values. Data on the bus side uses electrical levels on active-low lines, where a logical one travels as a low level. The decision is remade for every data phase, and nothing carries over from the phase before.

Both directions move one data phase per beat over a valid/ready handshake through a single register stage. A beat counter on each side marks the first and the last phase of every eight-phase cache-line burst.

Top module: `sbi_codec`

## Requirements
- R1: Flag bit i (i = 0..3) governs data bits 16*i+15 down to 16*i. Segment 0 is bits 15:0 and segment 3 is bits 63:48. Each segment is decided on its own bits alone.
- R2: Take a segment of `tx_data` with more than 8 one bits, which would drive more than 8 low lines. The encoder outputs that segment unchanged on `txo_bus` and drives its `txo_flag_n` bit to 0. Any other segment is output as its bitwise complement, and its flag bit is 1.
- R3: A segment with exactly 8 one bits is not inverted. Its `txo_bus` segment is the complement of the data, and its flag bit is 1.
- R4: Whenever `txo_valid` is 1, no 16-bit segment of `txo_bus` contains more than 8 zero bits.
- R5: The decoder outputs each `rxi_bus` segment whose `rxi_flag_n` bit is 0 unchanged on `rx_data`. It outputs the complement of each segment whose flag bit is 1.
- R6: A word passed through the encoder and then fed unchanged into the decoder comes out of the decoder equal to the original word.
- R7: A beat accepted on the transmit input (`tx_valid` and `tx_ready` both high at a rising edge) appears on `txo_bus` and `txo_flag_n` with `txo_valid` high from the next cycle. `tx_ready` is high whenever `txo_valid` is low or `txo_ready` is high.
- R8: While `txo_valid` is high and `txo_ready` is low, `txo_valid`, `txo_bus` and `txo_flag_n` hold their values.
- R9: The receive path has the same one-stage handshake as the transmit path. `rxi_ready` is high when `rx_valid` is low or `rx_ready` is high. An accepted beat appears on `rx_data` the next cycle, and it is held while stalled.
- R10: Each side counts the beats that leave its output. `txo_first` / `rx_first` are high while the count is 0. `txo_last` / `rx_last` are high while the count is 7. After the beat at count 7 leaves, the count returns to 0.
- R11: The encoded value of a word does not depend on the words sent before it.
- R12: While `rst_n` is low, `txo_valid` and `rx_valid` are 0 and `txo_first` and `rx_first` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Transmit input beat valid |
| tx_ready | output | 1 | Transmit input can accept a beat |
| tx_data | input | 64 | Logical word to encode |
| txo_valid | output | 1 | Encoded beat valid |
| txo_ready | input | 1 | Encoded beat consumer ready |
| txo_bus | output | 64 | Encoded word, electrical levels |
| txo_flag_n | output | 4 | Per-segment inversion flags, active low |
| txo_first | output | 1 | Current encoded beat is phase 0 of a burst |
| txo_last | output | 1 | Current encoded beat is phase 7 of a burst |
| rxi_valid | input | 1 | Received bus beat valid |
| rxi_ready | output | 1 | Receive input can accept a beat |
| rxi_bus | input | 64 | Received word, electrical levels |
| rxi_flag_n | input | 4 | Received per-segment inversion flags, active low |
| rx_valid | output | 1 | Decoded beat valid |
| rx_ready | input | 1 | Decoded beat consumer ready |
| rx_data | output | 64 | Decoded logical word |
| rx_first | output | 1 | Current decoded beat is phase 0 of a burst |
| rx_last | output | 1 | Current decoded beat is phase 7 of a burst |

## Verification
The encoder first sees directed words whose segments hold 0, 1, 7, 8, 9, 15 and 16 one bits. This separates a correct greater-than-8 test from a greater-or-equal test, an off-by-one count and a swapped flag polarity. Random words with sparse, dense and exactly-half segments follow, with stalls on the output, which test segment independence and the hold rule. The decoder takes either the encoder's own output, which checks the round trip, or random bus and flag pairs, which check each flag's effect on its own segment. Burst markers are compared against a beat count kept across stalls.

// File: rtl/sbi_pkg.sv
// Package: shared defaults and types for the segmented bus inversion codec.
// Assumes nothing beyond standard SystemVerilog.
package sbi_pkg;
    localparam int DEF_SEG_W     = 16;
    localparam int DEF_N_SEG     = 4;
    localparam int DEF_BURST_LEN = 8;

    // Burst position markers for one output beat
    typedef struct packed {
        logic first;
        logic last;
    } burst_mark_t;
endpackage

// File: rtl/sbi_seg_enc.sv
// Module: sbi_seg_enc
// Encodes one segment. A logical one maps to a low line. If more than half
// of the lines would be low, the segment is flipped and the flag (active low)
// is asserted. Purely combinational; assumes SEG_W is even.
module sbi_seg_enc #(
    parameter int SEG_W = 16
) (
    input  logic [SEG_W-1:0] data,
    output logic [SEG_W-1:0] bus,
    output logic             flag_n
);
    localparam int HALF = SEG_W / 2;

    logic flip;

    // Decide inversion from the count of would-be low lines
    always_comb begin
        flip   = ($countones(data) > HALF);
        bus    = flip ? data : ~data;
        flag_n = ~flip;
    end
endmodule

// File: rtl/sbi_seg_dec.sv
// Module: sbi_seg_dec
// Decodes one segment from electrical levels back to a logical value,
// undoing the flip when the active-low flag is asserted. Combinational.
module sbi_seg_dec #(
    parameter int SEG_W = 16
) (
    input  logic [SEG_W-1:0] bus,
    input  logic             flag_n,
    output logic [SEG_W-1:0] data
);
    // Select direct or complemented levels per the flag
    always_comb begin
        data = flag_n ? ~bus : bus;
    end
endmodule

// File: rtl/sbi_pipe.sv
// Module: sbi_pipe
// One-deep registered valid/ready stage. Accepts a beat when empty or when
// the held beat leaves in the same cycle. Payload holds while stalled.
module sbi_pipe #(
    parameter int W = 68
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    // Ready when the slot is free or draining now
    always_comb begin
        in_ready = !out_valid || out_ready;
    end

    // Valid flag update
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (in_ready)
            out_valid <= in_valid;
    end

    // Payload capture on accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_data <= '0;
        else if (in_valid && in_ready)
            out_data <= in_data;
    end
endmodule

// File: rtl/sbi_burst.sv
// Module: sbi_burst
// Counts beats leaving an output and marks the first and last phase of each
// burst of LEN beats. Wraps to zero after the last phase.
module sbi_burst
    import sbi_pkg::*;
#(
    parameter int LEN = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output burst_mark_t mark
);
    localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LEN - 1);

    logic [CNT_W-1:0] cnt;

    // Phase counter advance and wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
    end

    // Marker decode from the count
    always_comb begin
        mark.first = (cnt == '0);
        mark.last  = (cnt == LAST_IDX);
    end
endmodule

// File: rtl/sbi_codec.sv
// Module: sbi_codec (top)
// Segmented bus inversion encoder and decoder. The transmit side encodes
// logical words into bus levels plus active-low per-segment flags. The
// receive side reverses it. Each path is one registered handshake stage,
// and each output carries burst phase markers.
// Assumes data and flags on a beat belong together; no cross-beat state.
module sbi_codec
    import sbi_pkg::*;
#(
    parameter int SEG_W     = DEF_SEG_W,
    parameter int N_SEG     = DEF_N_SEG,
    parameter int BURST_LEN = DEF_BURST_LEN
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_valid,
    output logic                   tx_ready,
    input  logic [SEG_W*N_SEG-1:0] tx_data,
    output logic                   txo_valid,
    input  logic                   txo_ready,
    output logic [SEG_W*N_SEG-1:0] txo_bus,
    output logic [N_SEG-1:0]       txo_flag_n,
    output logic                   txo_first,
    output logic                   txo_last,
    input  logic                   rxi_valid,
    output logic                   rxi_ready,
    input  logic [SEG_W*N_SEG-1:0] rxi_bus,
    input  logic [N_SEG-1:0]       rxi_flag_n,
    output logic                   rx_valid,
    input  logic                   rx_ready,
    output logic [SEG_W*N_SEG-1:0] rx_data,
    output logic                   rx_first,
    output logic                   rx_last
);
    localparam int DATA_W = SEG_W * N_SEG;
    localparam int PAY_W  = DATA_W + N_SEG;

    logic [DATA_W-1:0] enc_bus;
    logic [N_SEG-1:0]  enc_flag_n;
    logic [DATA_W-1:0] dec_data;
    logic [PAY_W-1:0]  tx_pay;
    logic [DATA_W-1:0] rx_pay;
    burst_mark_t       tx_mark;
    burst_mark_t       rx_mark;

    // Per-segment encode and decode slices
    for (genvar g = 0; g < N_SEG; g++) begin : g_seg
        sbi_seg_enc #(.SEG_W(SEG_W)) u_enc (
            .data   (tx_data[g*SEG_W +: SEG_W]),
            .bus    (enc_bus[g*SEG_W +: SEG_W]),
            .flag_n (enc_flag_n[g])
        );
        sbi_seg_dec #(.SEG_W(SEG_W)) u_dec (
            .bus    (rxi_bus[g*SEG_W +: SEG_W]),
            .flag_n (rxi_flag_n[g]),
            .data   (dec_data[g*SEG_W +: SEG_W])
        );
    end

    // Transmit stage: data and flags registered together
    sbi_pipe #(.W(PAY_W)) u_tx_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_valid),
        .in_ready  (tx_ready),
        .in_data   ({enc_flag_n, enc_bus}),
        .out_valid (txo_valid),
        .out_ready (txo_ready),
        .out_data  (tx_pay)
    );

    // Receive stage
    sbi_pipe #(.W(DATA_W)) u_rx_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rxi_valid),
        .in_ready  (rxi_ready),
        .in_data   (dec_data),
        .out_valid (rx_valid),
        .out_ready (rx_ready),
        .out_data  (rx_pay)
    );

    // Burst phase tracking on each output
    sbi_burst #(.LEN(BURST_LEN)) u_tx_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (txo_valid && txo_ready),
        .mark  (tx_mark)
    );

    sbi_burst #(.LEN(BURST_LEN)) u_rx_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rx_valid && rx_ready),
        .mark  (rx_mark)
    );

    // Output unpacking
    always_comb begin
        txo_bus    = tx_pay[DATA_W-1:0];
        txo_flag_n = tx_pay[PAY_W-1:DATA_W];
        rx_data    = rx_pay;
        txo_first  = tx_mark.first;
        txo_last   = tx_mark.last;
        rx_first   = rx_mark.first;
        rx_last    = rx_mark.last;
    end
endmodule

// File: rtl/sbi_codec_chk.sv
// Module: sbi_codec_chk
// Property checker for sbi_codec, attached with bind. Observes ports only.
module sbi_codec_chk #(
    parameter int SEG_W     = 16,
    parameter int N_SEG     = 4,
    parameter int BURST_LEN = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tx_valid,
    input logic                   tx_ready,
    input logic                   txo_valid,
    input logic                   txo_ready,
    input logic [SEG_W*N_SEG-1:0] txo_bus,
    input logic [N_SEG-1:0]       txo_flag_n,
    input logic                   txo_last,
    input logic                   txo_first,
    input logic                   rxi_valid,
    input logic                   rxi_ready,
    input logic                   rx_valid,
    input logic                   rx_ready,
    input logic [SEG_W*N_SEG-1:0] rx_data
);
    localparam int HALF = SEG_W / 2;

    for (genvar g = 0; g < N_SEG; g++) begin : g_seg_chk
        AST_TX_LOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            txo_valid |-> ($countones(~txo_bus[g*SEG_W +: SEG_W]) <= HALF)); // R4
        AST_FLAG_MEANS_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
            (txo_valid && !txo_flag_n[g]) |-> ($countones(txo_bus[g*SEG_W +: SEG_W]) > HALF)); // R2
    end

    AST_TX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> txo_valid); // R7
    AST_TX_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !txo_valid |-> tx_ready); // R7
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (txo_valid && !txo_ready) |=> (txo_valid && $stable(txo_bus) && $stable(txo_flag_n))); // R8
    AST_RX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rxi_valid && rxi_ready) |=> rx_valid); // R9
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R9
    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (txo_valid && txo_ready && txo_last) |=> txo_first); // R10
endmodule

bind sbi_codec sbi_codec_chk #(
    .SEG_W(SEG_W), .N_SEG(N_SEG), .BURST_LEN(BURST_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txo_valid(txo_valid), .txo_ready(txo_ready),
    .txo_bus(txo_bus), .txo_flag_n(txo_flag_n),
    .txo_last(txo_last), .txo_first(txo_first),
    .rxi_valid(rxi_valid), .rxi_ready(rxi_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/sbi_codec_tb.sv
// Bench: behavioural queue model of both paths, compared every cycle.
module sbi_codec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0, txo_ready = 1'b0, rxi_valid = 1'b0, rx_ready = 1'b0;
    logic [63:0] tx_data = '0, rxi_bus = '0;
    logic [3:0]  rxi_flag_n = '1;
    logic        tx_ready, txo_valid, txo_first, txo_last;
    logic        rxi_ready, rx_valid, rx_first, rx_last;
    logic [63:0] txo_bus, rx_data;
    logic [3:0]  txo_flag_n;

    always #4 clk = ~clk;

    sbi_codec u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .txo_valid(txo_valid), .txo_ready(txo_ready), .txo_bus(txo_bus),
        .txo_flag_n(txo_flag_n), .txo_first(txo_first), .txo_last(txo_last),
        .rxi_valid(rxi_valid), .rxi_ready(rxi_ready), .rxi_bus(rxi_bus),
        .rxi_flag_n(rxi_flag_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_first(rx_first), .rx_last(rx_last)
    );

    typedef struct packed { logic [63:0] orig; logic [63:0] bus; logic [3:0] fl; } ent_t;
    typedef struct packed { logic [63:0] data; logic loop; } rxe_t;

    ent_t        txq[$];
    ent_t        loopq[$];
    rxe_t        rxq[$];
    int          checks = 0, fails = 0;
    int          txph = 0, rxph = 0, wi = 0;
    bit          done = 1'b0, tx_pend = 1'b0, rx_pend = 1'b0;
    bit          rx_cur_loop = 1'b0;
    logic [63:0] rx_cur_orig = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ones16(input logic [15:0] v);
        int n = 0;
        for (int b = 0; b < 16; b++) n += int'(v[b]);
        return n;
    endfunction

    function automatic ent_t model_enc(input logic [63:0] d);
        ent_t e;
        e.orig = d;
        for (int s = 0; s < 4; s++) begin
            if (ones16(d[s*16 +: 16]) > 8) begin
                e.bus[s*16 +: 16] = d[s*16 +: 16];
                e.fl[s] = 1'b0;
            end else begin
                e.bus[s*16 +: 16] = ~d[s*16 +: 16];
                e.fl[s] = 1'b1;
            end
        end
        return e;
    endfunction

    function automatic logic [63:0] model_dec(input logic [63:0] b, input logic [3:0] f);
        logic [63:0] d;
        for (int s = 0; s < 4; s++)
            d[s*16 +: 16] = f[s] ? ~b[s*16 +: 16] : b[s*16 +: 16];
        return d;
    endfunction

    function automatic logic [15:0] rand_seg();
        logic [15:0] a = 16'($urandom);
        logic [15:0] b = 16'($urandom);
        case ($urandom % 5)
            0: return a & b;
            1: return a | b;
            2: return 16'h00FF << ($urandom % 9);
            3: return a & b & 16'($urandom);
            default: return a;
        endcase
    endfunction

    function automatic logic [63:0] next_word(input int idx);
        case (idx)
            0: return 64'h0000_0000_0000_0000;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h00FF_00FF_00FF_00FF;
            3: return 64'h01FF_007F_FFFF_0000;
            4: return 64'hFF00_0F0F_3333_5555;
            5: return 64'h8000_FFFE_7FFF_0001;
            6: return 64'h01FF_007F_FFFF_0000;
            7: return 64'hAAAA_0000_FFFF_00FF;
            default: return {rand_seg(), rand_seg(), rand_seg(), rand_seg()};
        endcase
    endfunction

    // Compare outputs with the model state reached after the last edge
    task automatic check_outputs();
        chk(txo_valid == (txq.size() != 0), "R7 txo_valid", 64'(txo_valid), 64'(txq.size() != 0));
        if (txo_valid && txq.size() != 0) begin
            chk(txo_bus == txq[0].bus, "R2 R11 txo_bus", txo_bus, txq[0].bus);
            for (int s = 0; s < 4; s++) begin
                chk(txo_flag_n[s] == txq[0].fl[s],
                    (ones16(txq[0].orig[s*16 +: 16]) == 8) ? "R3 flag" : "R1 flag",
                    64'(txo_flag_n), 64'(txq[0].fl));
                chk((16 - ones16(txo_bus[s*16 +: 16])) <= 8, "R4 low count",
                    64'(16 - ones16(txo_bus[s*16 +: 16])), 64'd8);
            end
        end
        chk(txo_first == (txph == 0), "R10 txo_first", 64'(txo_first), 64'(txph == 0));
        chk(txo_last == (txph == 7), "R10 txo_last", 64'(txo_last), 64'(txph == 7));
        chk(rx_valid == (rxq.size() != 0), "R9 rx_valid", 64'(rx_valid), 64'(rxq.size() != 0));
        if (rx_valid && rxq.size() != 0)
            chk(rx_data == rxq[0].data, rxq[0].loop ? "R6 round trip" : "R5 decode",
                rx_data, rxq[0].data);
        chk(rx_first == (rxph == 0), "R10 rx_first", 64'(rx_first), 64'(rxph == 0));
        chk(rx_last == (rxph == 7), "R10 rx_last", 64'(rx_last), 64'(rxph == 7));
    endtask

    // Present new inputs unless a beat is still waiting
    task automatic drive(input int cyc);
        if (!tx_pend) begin
            tx_valid = (cyc < 20) || ($urandom % 4 != 0);
            if (tx_valid) begin
                tx_data = next_word(wi);
                wi++;
            end
        end
        txo_ready = (cyc < 20) || ((cyc % 200) > 150) ? 1'b1 : ($urandom % 10 < 6);
        rx_ready  = ($urandom % 10 < 7);
        if (!rx_pend) begin
            if (loopq.size() != 0 && ($urandom % 4 != 0)) begin
                ent_t e = loopq.pop_front();
                rxi_valid   = 1'b1;
                rxi_bus     = e.bus;
                rxi_flag_n  = e.fl;
                rx_cur_loop = 1'b1;
                rx_cur_orig = e.orig;
            end else begin
                rxi_valid   = ($urandom % 2 == 0);
                rxi_bus     = {$urandom, $urandom};
                rxi_flag_n  = 4'($urandom);
                rx_cur_loop = 1'b0;
            end
        end
    endtask

    // Predict what the coming edge does
    task automatic advance();
        bit tin, tout, rin, rout;
        chk(tx_ready == ((txq.size() == 0) || txo_ready), "R7 tx_ready",
            64'(tx_ready), 64'((txq.size() == 0) || txo_ready));
        chk(rxi_ready == ((rxq.size() == 0) || rx_ready), "R9 rxi_ready",
            64'(rxi_ready), 64'((rxq.size() == 0) || rx_ready));
        tin  = tx_valid && tx_ready;
        tout = txo_valid && txo_ready;
        rin  = rxi_valid && rxi_ready;
        rout = rx_valid && rx_ready;
        if (tout && txq.size() != 0) begin
            ent_t e = txq.pop_front();
            ent_t o;
            o.orig = e.orig;
            o.bus  = txo_bus;
            o.fl   = txo_flag_n;
            loopq.push_back(o);
            txph = (txph + 1) % 8;
        end
        if (tin) txq.push_back(model_enc(tx_data));
        tx_pend = tx_valid && !tin;
        if (rout && rxq.size() != 0) begin
            void'(rxq.pop_front());
            rxph = (rxph + 1) % 8;
        end
        if (rin) begin
            rxe_t r;
            r.loop = rx_cur_loop;
            r.data = rx_cur_loop ? rx_cur_orig : model_dec(rxi_bus, rxi_flag_n);
            rxq.push_back(r);
        end
        rx_pend = rxi_valid && !rin;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(txo_valid == 1'b0, "R12 reset txo_valid", 64'(txo_valid), 64'd0);
            chk(rx_valid == 1'b0, "R12 reset rx_valid", 64'(rx_valid), 64'd0);
            chk(txo_first == 1'b1, "R12 reset txo_first", 64'(txo_first), 64'd1);
            chk(rx_first == 1'b1, "R12 reset rx_first", 64'(rx_first), 64'd1);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            check_outputs();
            drive(cyc);
            #1;
            advance();
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule